// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block holds the coherence record for a single memory block in a directory-based multiprocessor. It does not keep a full presence vector. It stores a small, fixed number of processor-ID pointers that name the caches holding a copy. A request names an operation (read miss, write miss or eviction notice) and a processor ID. The entry replies with three things: the set of processors whose copies must be invalidated, an optional writeback demand aimed at the current dirty owner, and a grant flag.

When every pointer slot is occupied and another processor reads the block, a compile-time parameter picks one of three policies. In the first, an existing pointer is displaced round-robin and its holder is invalidated. In the second, the entry raises a sticky flag that makes the next write invalidate every processor. In the third, the entry changes its record into a coarse vector, in which each bit stands for a group of processors. A 2-bit state field tells whether the block is uncached, held clean by one cache, held clean by several caches, or held dirty by one cache.

Top module: `lpd_dir_entry`

## Requirements
- R1: After reset, `dir_state` is 0 (uncached), `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its response appears at the next edge. `req_ready` stays 0 while a response is pending. The response holds steady until a cycle with `rsp_ready` at 1, and a request offered during that time is not taken.
- R3: `dir_state` encodes 0 = uncached, 1 = clean in exactly one cache, 2 = clean in more than one cache (or the entry has overflowed), 3 = dirty in exactly one cache.
- R4: A read (`req_op` = 0) from a processor not yet recorded places its ID in the lowest free pointer slot. A read from a processor already recorded changes nothing. A read or write is answered with `rsp_grant` = 1.
- R5: A read from a processor other than the owner of a dirty block returns `rsp_wb` = 1 and `rsp_wb_pid` = the owner. It also records the reader and leaves state 2. A read by the owner itself keeps state 3 and raises no writeback.
- R6: A write (`req_op` = 1) from processor p returns in `rsp_inval` every current sharer except p (bit k stands for processor k). Afterwards the entry records only p, in state 3, with the overflow flag and coarse mode cleared.
- R7: In replacement mode (`OVF_MODE` = 0), a read that finds all slots full displaces the slot named by a rotating index. The displaced processor is returned as the only bit of `rsp_inval`. The index starts at slot 0, advances by one on each overflow and returns to 0 on a write or when the entry becomes uncached.
- R8: In broadcast mode (`OVF_MODE` = 1), an overflowing read invalidates nothing and sets the overflow flag. While the flag is set, a write invalidates all processors except the writer.
- R9: In coarse mode (`OVF_MODE` = 2), an overflowing read converts the pointers and the new reader into a group vector in which group g covers processors g*GROUP to g*GROUP+GROUP-1. Later reads set their group's bit. A write then invalidates every processor in a marked group except the writer.
- R10: An eviction (`req_op` = 2) returns `rsp_grant` = 0 and an empty `rsp_inval`, and frees the evicting processor's pointer. An entry with one sharer left goes to state 1, or stays in state 3 if that sharer is the dirty owner. When the last pointer leaves, the entry returns to state 0. An eviction by an unrecorded processor, or one arriving while the overflow flag or coarse mode is active, leaves the entry unchanged.
- R11: `req_op` = 3 is accepted and answered with no grant, no invalidation and no writeback, and it leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Entry can take a request |
| req_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| req_pid | input | PID_W | Requesting processor ID |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Response consumed |
| rsp_inval | output | N_PROC | Processors to invalidate, one bit each |
| rsp_wb | output | 1 | Owner must write back before the grant |
| rsp_wb_pid | output | PID_W | Owner that must write back |
| rsp_grant | output | 1 | Read or write granted |
| dir_state | output | 2 | Block state code |

## Verification
The assertions assume that the requester holds `req_op` and `req_pid` steady in any cycle where `req_valid` is 1. They also assume that every processor ID is below `N_PROC`, and that an eviction comes only from a processor that is really giving up its copy. The bench drives every request at the falling edge and drops `req_valid` right after the accepting edge. It keeps all IDs within the eight processors of the default configuration. It feeds the same request stream to three entries, one for each overflow policy, so the invariants are checked under every policy.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

  typedef enum logic [1:0] {
    ST_ABSENT = 2'd0,
    ST_ONE    = 2'd1,
    ST_MANY   = 2'd2,
    ST_DIRTY  = 2'd3
  } blk_state_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NOP   = 2'd3
  } req_op_e;

  localparam int unsigned OVF_REPLACE = 0;
  localparam int unsigned OVF_BCAST   = 1;
  localparam int unsigned OVF_COARSE  = 2;

  // State from the number of recorded pointers; wide = flag or coarse active.
  function automatic blk_state_e settle_state(input int unsigned n,
                                              input logic wide,
                                              input logic keep_dirty);
    if (wide)   return ST_MANY;
    if (n == 0) return ST_ABSENT;
    if (n == 1) return keep_dirty ? ST_DIRTY : ST_ONE;
    return ST_MANY;
  endfunction

endpackage

// File: rtl/lpd_ptr_lookup.sv
module lpd_ptr_lookup #(
  parameter int unsigned N_PTR = 2,
  parameter int unsigned PID_W = 3,
  parameter int unsigned IDX_W = 1
) (
  input  logic [N_PTR-1:0]            vld,
  input  logic [N_PTR-1:0][PID_W-1:0] ptrs,
  input  logic [PID_W-1:0]            pid,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx,
  output logic                        has_free,
  output logic [IDX_W-1:0]            free_idx
);
  logic [N_PTR-1:0] hit_vec;

  for (genvar k = 0; k < N_PTR; k++) begin : g_cmp
    assign hit_vec[k] = vld[k] && (ptrs[k] == pid);
  end

  assign hit      = |hit_vec;
  assign has_free = ~&vld;

  // Lowest matching / lowest free slot wins.
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int k = N_PTR - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_idx  = IDX_W'(k);
      if (!vld[k])    free_idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/lpd_sharer_map.sv
module lpd_sharer_map #(
  parameter int unsigned N_PROC = 8,
  parameter int unsigned N_PTR  = 2,
  parameter int unsigned PID_W  = 3,
  parameter int unsigned GROUP  = 2,
  parameter int unsigned NGRP   = 4
) (
  input  logic [N_PTR-1:0]            vld,
  input  logic [N_PTR-1:0][PID_W-1:0] ptrs,
  input  logic                        bcast,
  input  logic                        coarse,
  input  logic [NGRP-1:0]             cvec,
  output logic [N_PROC-1:0]           sharers
);
  for (genvar q = 0; q < N_PROC; q++) begin : g_proc
    logic [N_PTR-1:0] m;
    for (genvar k = 0; k < N_PTR; k++) begin : g_slot
      assign m[k] = vld[k] && (ptrs[k] == PID_W'(q));
    end
    assign sharers[q] = bcast | (coarse & cvec[q / GROUP]) | (|m);
  end
endmodule

// File: rtl/lpd_dir_entry.sv
module lpd_dir_entry
  import lpd_pkg::*;
#(
  parameter int unsigned N_PROC   = 8,
  parameter int unsigned N_PTR    = 2,
  parameter int unsigned GROUP    = 2,
  parameter int unsigned OVF_MODE = OVF_REPLACE,
  parameter int unsigned PID_W    = $clog2(N_PROC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [PID_W-1:0]  req_pid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [N_PROC-1:0] rsp_inval,
  output logic              rsp_wb,
  output logic [PID_W-1:0]  rsp_wb_pid,
  output logic              rsp_grant,
  output logic [1:0]        dir_state
);
  localparam int unsigned IDX_W = (N_PTR > 1) ? $clog2(N_PTR) : 1;
  localparam int unsigned NGRP  = N_PROC / GROUP;
  localparam int unsigned NGW   = (NGRP > 1) ? $clog2(NGRP) : 1;

  function automatic int unsigned count_set(input logic [N_PTR-1:0] v);
    int unsigned n = 0;
    for (int k = 0; k < N_PTR; k++) n += int'(v[k]);
    return n;
  endfunction

  function automatic logic [NGW-1:0] grp_of(input logic [PID_W-1:0] p);
    return NGW'(int'(p) / GROUP);
  endfunction

  function automatic logic [N_PROC-1:0] bit_of(input logic [PID_W-1:0] p);
    return {{(N_PROC-1){1'b0}}, 1'b1} << p;
  endfunction

  function automatic logic [IDX_W-1:0] rr_next(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(N_PTR - 1)) ? '0 : i + 1'b1;
  endfunction

  // Entry state
  logic [N_PTR-1:0]            vld_q, vld_d;
  logic [N_PTR-1:0][PID_W-1:0] ptr_q, ptr_d;
  logic                        bcast_q, bcast_d;
  logic                        coarse_q, coarse_d;
  logic [NGRP-1:0]             cvec_q, cvec_d;
  logic [IDX_W-1:0]            rr_q, rr_d;
  blk_state_e                  st_q, st_d;

  // Response registers
  logic              rv_q;
  logic [N_PROC-1:0] inv_q, inv_d;
  logic              wb_q, wb_d;
  logic [PID_W-1:0]  wbp_q, wbp_d;
  logic              gr_q, gr_d;

  logic              hit, has_free;
  logic [IDX_W-1:0]  hit_idx, free_idx;
  logic [N_PROC-1:0] cur_sharers;

  // Named events for the checker
  logic evt_accept, evt_overflow, evt_rsp_done;

  lpd_ptr_lookup #(.N_PTR(N_PTR), .PID_W(PID_W), .IDX_W(IDX_W)) u_look (
    .vld(vld_q), .ptrs(ptr_q), .pid(req_pid),
    .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
  );

  lpd_sharer_map #(.N_PROC(N_PROC), .N_PTR(N_PTR), .PID_W(PID_W),
                   .GROUP(GROUP), .NGRP(NGRP)) u_map (
    .vld(vld_q), .ptrs(ptr_q), .bcast(bcast_q), .coarse(coarse_q),
    .cvec(cvec_q), .sharers(cur_sharers)
  );

  assign req_ready    = !rv_q;
  assign evt_accept   = req_valid && req_ready;
  assign evt_rsp_done = rv_q && rsp_ready;
  assign evt_overflow = evt_accept && (req_op == OP_READ) && !hit && !has_free
                        && !bcast_q && !coarse_q;

  always_comb begin
    vld_d    = vld_q;
    ptr_d    = ptr_q;
    bcast_d  = bcast_q;
    coarse_d = coarse_q;
    cvec_d   = cvec_q;
    rr_d     = rr_q;
    st_d     = st_q;
    inv_d    = '0;
    wb_d     = 1'b0;
    wbp_d    = '0;
    gr_d     = 1'b0;
    case (req_op_e'(req_op))
      OP_READ: begin
        gr_d = 1'b1;
        if (st_q == ST_DIRTY && !hit) begin
          wb_d  = 1'b1;
          wbp_d = ptr_q[0];
        end
        if (coarse_q) begin
          cvec_d[grp_of(req_pid)] = 1'b1;
        end else if (!bcast_q && !hit) begin
          if (has_free) begin
            vld_d[free_idx] = 1'b1;
            ptr_d[free_idx] = req_pid;
          end else if (OVF_MODE == OVF_REPLACE) begin
            inv_d        = bit_of(ptr_q[rr_q]);
            ptr_d[rr_q]  = req_pid;
            rr_d         = rr_next(rr_q);
          end else if (OVF_MODE == OVF_BCAST) begin
            bcast_d = 1'b1;
          end else begin
            for (int k = 0; k < N_PTR; k++)
              if (vld_q[k]) cvec_d[grp_of(ptr_q[k])] = 1'b1;
            cvec_d[grp_of(req_pid)] = 1'b1;
            coarse_d = 1'b1;
            vld_d    = '0;
          end
        end
        st_d = (st_q == ST_DIRTY && hit) ? ST_DIRTY
             : settle_state(count_set(vld_d), bcast_d | coarse_d, 1'b0);
      end
      OP_WRITE: begin
        gr_d     = 1'b1;
        inv_d    = cur_sharers & ~bit_of(req_pid);
        vld_d    = '0;
        vld_d[0] = 1'b1;
        ptr_d    = '0;
        ptr_d[0] = req_pid;
        bcast_d  = 1'b0;
        coarse_d = 1'b0;
        cvec_d   = '0;
        rr_d     = '0;
        st_d     = ST_DIRTY;
      end
      OP_EVICT: begin
        if (!bcast_q && !coarse_q && hit) begin
          vld_d[hit_idx] = 1'b0;
          st_d = settle_state(count_set(vld_d), 1'b0, st_q == ST_DIRTY);
          if (count_set(vld_d) == 0) rr_d = '0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= '0;
      ptr_q    <= '0;
      bcast_q  <= 1'b0;
      coarse_q <= 1'b0;
      cvec_q   <= '0;
      rr_q     <= '0;
      st_q     <= ST_ABSENT;
      rv_q     <= 1'b0;
      inv_q    <= '0;
      wb_q     <= 1'b0;
      wbp_q    <= '0;
      gr_q     <= 1'b0;
    end else if (evt_accept) begin
      vld_q    <= vld_d;
      ptr_q    <= ptr_d;
      bcast_q  <= bcast_d;
      coarse_q <= coarse_d;
      cvec_q   <= cvec_d;
      rr_q     <= rr_d;
      st_q     <= st_d;
      rv_q     <= 1'b1;
      inv_q    <= inv_d;
      wb_q     <= wb_d;
      wbp_q    <= wbp_d;
      gr_q     <= gr_d;
    end else if (evt_rsp_done) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid  = rv_q;
  assign rsp_inval  = inv_q;
  assign rsp_wb     = wb_q;
  assign rsp_wb_pid = wbp_q;
  assign rsp_grant  = gr_q;
  assign dir_state  = st_q;
endmodule

// File: rtl/lpd_dir_entry_chk.sv
module lpd_dir_entry_chk #(
  parameter int unsigned N_PROC = 8,
  parameter int unsigned N_PTR  = 2,
  parameter int unsigned PID_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [PID_W-1:0]  req_pid,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [N_PROC-1:0] rsp_inval,
  input logic              rsp_grant,
  input logic [1:0]        dir_state,
  input logic [N_PTR-1:0]  vld_q,
  input logic              bcast_q,
  input logic              coarse_q,
  input logic              evt_accept,
  input logic              evt_overflow
);
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_inval) && $stable(rsp_grant));

  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_one_holder_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_state == 2'd1 |-> $countones(vld_q) == 1 && !bcast_q && !coarse_q);

  p_dirty_slot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_state == 2'd3 |-> vld_q == N_PTR'(1) && !bcast_q && !coarse_q);

  p_write_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && req_op == 2'd1 |=> !rsp_inval[$past(req_pid)] && dir_state == 2'd3
                                      && rsp_grant);

  p_read_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && req_op == 2'd0 |=> $countones(rsp_inval) <= 1 && rsp_grant);

  p_overflow_many_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |=> dir_state == 2'd2);

  p_absent_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dir_state == 2'd0 |-> vld_q == '0 && !bcast_q && !coarse_q);

  p_evict_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && req_op == 2'd2 |=> !rsp_grant && rsp_inval == '0);

  p_nop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && req_op == 2'd3 |=> !rsp_grant && rsp_inval == '0
                                      && dir_state == $past(dir_state));
endmodule

bind lpd_dir_entry lpd_dir_entry_chk #(.N_PROC(N_PROC), .N_PTR(N_PTR), .PID_W(PID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_op(req_op), .req_pid(req_pid),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_inval(rsp_inval),
  .rsp_grant(rsp_grant), .dir_state(dir_state), .vld_q(vld_q), .bcast_q(bcast_q),
  .coarse_q(coarse_q), .evt_accept(evt_accept), .evt_overflow(evt_overflow)
);

// File: tb/sim_lpd_dir_entry.sv
`timescale 1ns/1ps
module sim_lpd_dir_entry;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [2:0] req_pid = '0;
  logic rsp_ready = 1'b0;

  logic [2:0] rdy, rv, wb, gr;
  logic [7:0] inv [3];
  logic [2:0] wbp [3];
  logic [1:0] st  [3];

  logic [7:0] c_inv [3];
  logic [2:0] c_wbp [3];
  logic [1:0] c_st  [3];
  logic [2:0] c_wb, c_gr;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  lpd_dir_entry #(.OVF_MODE(0)) u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_ready(rdy[0]), .req_op(req_op), .req_pid(req_pid), .rsp_valid(rv[0]),
    .rsp_ready(rsp_ready), .rsp_inval(inv[0]), .rsp_wb(wb[0]), .rsp_wb_pid(wbp[0]),
    .rsp_grant(gr[0]), .dir_state(st[0]));
  lpd_dir_entry #(.OVF_MODE(1)) u1 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_ready(rdy[1]), .req_op(req_op), .req_pid(req_pid), .rsp_valid(rv[1]),
    .rsp_ready(rsp_ready), .rsp_inval(inv[1]), .rsp_wb(wb[1]), .rsp_wb_pid(wbp[1]),
    .rsp_grant(gr[1]), .dir_state(st[1]));
  lpd_dir_entry #(.OVF_MODE(2)) u2 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_ready(rdy[2]), .req_op(req_op), .req_pid(req_pid), .rsp_valid(rv[2]),
    .rsp_ready(rsp_ready), .rsp_inval(inv[2]), .rsp_wb(wb[2]), .rsp_wb_pid(wbp[2]),
    .rsp_grant(gr[2]), .dir_state(st[2]));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // One transaction to all three entries; response consumed one cycle later.
  task automatic req(input logic [1:0] op, input logic [2:0] pid);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_pid = pid;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int m = 0; m < 3; m++) begin
      c_inv[m] = inv[m]; c_wbp[m] = wbp[m]; c_st[m] = st[m];
    end
    c_wb = wb; c_gr = gr;
    chk("R2 rsp_valid one cycle after accept", {29'd0, rv}, 32'h7);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic chk_inv(input string tag, input logic [7:0] e0, input logic [7:0] e1,
                         input logic [7:0] e2);
    chk({tag, " u0 inval"}, {24'd0, c_inv[0]}, {24'd0, e0});
    chk({tag, " u1 inval"}, {24'd0, c_inv[1]}, {24'd0, e1});
    chk({tag, " u2 inval"}, {24'd0, c_inv[2]}, {24'd0, e2});
  endtask

  task automatic chk_st(input string tag, input logic [1:0] e0, input logic [1:0] e1,
                        input logic [1:0] e2);
    chk({tag, " u0 state"}, {30'd0, c_st[0]}, {30'd0, e0});
    chk({tag, " u1 state"}, {30'd0, c_st[1]}, {30'd0, e1});
    chk({tag, " u2 state"}, {30'd0, c_st[2]}, {30'd0, e2});
  endtask

  task automatic t_reset;
    chk("R1 state after reset", {26'd0, st[0], st[1], st[2]}, 32'd0);
    chk("R1 rsp_valid after reset", {29'd0, rv}, 32'd0);
    chk("R1 req_ready after reset", {29'd0, rdy}, 32'h7);
  endtask

  task automatic t_grow;
    req(2'd0, 3'd1);
    chk_inv("R4 first read", 8'h00, 8'h00, 8'h00);
    chk_st("R3 first read", 2'd1, 2'd1, 2'd1);
    chk("R4 read grant", {29'd0, c_gr}, 32'h7);
    req(2'd0, 3'd1);
    chk_st("R4 repeat read", 2'd1, 2'd1, 2'd1);
    req(2'd0, 3'd3);
    chk_st("R3 two sharers", 2'd2, 2'd2, 2'd2);
    req(2'd0, 3'd5);
    chk_inv("R7 R8 R9 first overflow", 8'h02, 8'h00, 8'h00);
    chk_st("R8 overflow state", 2'd2, 2'd2, 2'd2);
    req(2'd0, 3'd4);
    chk_inv("R7 second victim", 8'h08, 8'h00, 8'h00);
    req(2'd1, 3'd2);
    chk_inv("R6 R8 R9 write after overflow", 8'h30, 8'hFB, 8'h3B);
    chk_st("R6 write state", 2'd3, 2'd3, 2'd3);
    chk("R6 write grant", {29'd0, c_gr}, 32'h7);
  endtask

  task automatic t_dirty_read;
    req(2'd0, 3'd7);
    chk("R5 writeback flag", {29'd0, c_wb}, 32'h7);
    chk("R5 writeback owner", {23'd0, c_wbp[0], c_wbp[1], c_wbp[2]}, {23'd0, 3'd2, 3'd2, 3'd2});
    chk_st("R5 state after dirty read", 2'd2, 2'd2, 2'd2);
    chk_inv("R5 no inval", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_evict;
    req(2'd2, 3'd2);
    chk_st("R10 evict owner leaves one", 2'd1, 2'd1, 2'd1);
    chk("R10 evict no grant", {29'd0, c_gr}, 32'h0);
    req(2'd2, 3'd5);
    chk_st("R10 evict non-sharer", 2'd1, 2'd1, 2'd1);
    chk_inv("R10 evict no inval", 8'h00, 8'h00, 8'h00);
    req(2'd2, 3'd7);
    chk_st("R10 last sharer leaves", 2'd0, 2'd0, 2'd0);
    req(2'd3, 3'd4);
    chk_st("R11 no-op state", 2'd0, 2'd0, 2'd0);
    chk("R11 no-op grant", {29'd0, c_gr}, 32'h0);
    chk_inv("R11 no-op inval", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_ovf_evict;
    req(2'd0, 3'd0);
    req(2'd0, 3'd1);
    req(2'd0, 3'd2);
    chk_inv("R7 rotation restarted at slot 0", 8'h01, 8'h00, 8'h00);
    req(2'd2, 3'd1);
    chk_st("R10 evict under overflow", 2'd1, 2'd2, 2'd2);
    req(2'd1, 3'd3);
    chk_inv("R8 R9 write after ignored evict", 8'h04, 8'hF7, 8'h07);
    req(2'd0, 3'd3);
    chk("R5 owner read no writeback", {29'd0, c_wb}, 32'h0);
    chk_st("R5 owner read stays dirty", 2'd3, 2'd3, 2'd3);
    req(2'd2, 3'd3);
    chk_st("R10 owner evicts", 2'd0, 2'd0, 2'd0);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_pid = 3'd6;
    @(posedge clk);
    @(negedge clk);
    req_op = 2'd1; req_pid = 3'd0;   // offered while busy: must not be taken
    for (int c = 0; c < 3; c++) begin
      chk("R2 rsp held", {29'd0, rv}, 32'h7);
      chk("R2 ready low while busy", {29'd0, rdy}, 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R2 held grant", {29'd0, gr}, 32'h7);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R2 rsp cleared", {29'd0, rv}, 32'h0);
    chk("R2 busy write not taken", {26'd0, st[0], st[1], st[2]}, {26'd0, 2'd1, 2'd1, 2'd1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_grow;
    t_dirty_read;
    t_evict;
    t_ovf_evict;
    t_handshake;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule